// File: doc/BRIEF.md
# Ternary Line Frame Multiplexer

This block is the transmit-side framer of a two-wire 4B3T line. On every symbol-rate strobe it emits one ternary symbol, and it lays those symbols out as 120-symbol frames, one frame per millisecond at 120 kbaud. Each frame carries three kinds of content:

- an 11-symbol Barker synchronization word, sent unscrambled;
- one unscrambled maintenance/service symbol, which forms a 1 kbaud side channel;
- 108 scrambled data symbols that carry the B+B+D payload.

Scrambling and the 4-bit-to-3-symbol code conversion take place upstream. The data symbols arrive already coded, through a valid/take handshake.

The position of the sync word in the frame depends on the transmit direction, which a static strap selects. With the strap low, the word fills symbols 1 to 11 and the maintenance symbol is symbol 120. With the strap high, the word fills symbols 61 to 71 and the maintenance symbol is symbol 60. A polarity input inverts the sync word. When a data slot comes up and no data is ready, a zero symbol is sent and a sticky underrun flag is raised. A start-of-frame strobe marks symbol 1.

Top module: `tern_frame_mux`

## Requirements
- R1: After reset, `line_vld`, `sof`, `underrun` and `line_sym` are all 0. The first symbol sent is symbol 1 of a frame.
- R2: Each cycle with `sym_en` high produces exactly one output symbol, with `line_vld` high in the following cycle. Without `sym_en`, `line_vld` is low. Frames repeat every 120 symbols.
- R3: Symbol codes are 2'b01 for +, 2'b11 for − and 2'b00 for 0. An input code of 2'b10 on the data or maintenance input is sent as 2'b00.
- R4: With `dir_sel` = 0, symbols 1 to 11 carry the sync word and symbol 120 carries the maintenance symbol.
- R5: With `dir_sel` = 1, symbols 61 to 71 carry the sync word and symbol 60 carries the maintenance symbol.
- R6: The sync word is + + + − − − + − − + −, in sending order. With `sync_inv` = 1, every sync symbol is sent with the opposite sign.
- R7: `dat_take` is high exactly in a cycle that has `sym_en` high, a data slot and `dat_vld` high. Data symbols appear on the line in the order they are taken.
- R8: If a data slot occurs with `dat_vld` low, the symbol sent is 0, nothing is taken, and `underrun` goes high one cycle later. `underrun` then stays high until reset.
- R9: `sof` is high together with `line_vld` on symbol 1 of every frame, and never on any other symbol.
- R10: The maintenance symbol is sampled in its own slot. A low `dat_vld` in a sync or maintenance slot neither takes data nor raises `underrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sym_en | input | 1 | Symbol-rate strobe |
| dir_sel | input | 1 | Direction strap, held static |
| sync_inv | input | 1 | Invert the sync word polarity |
| dat_sym | input | 2 | Coded ternary data symbol |
| dat_vld | input | 1 | Data symbol ready |
| dat_take | output | 1 | Data symbol consumed this cycle |
| maint_sym | input | 2 | Maintenance/service symbol |
| line_sym | output | 2 | Encoded ternary output symbol |
| line_vld | output | 1 | `line_sym` is new this cycle |
| sof | output | 1 | Start of frame, symbol 1 |
| underrun | output | 1 | Sticky data starvation flag |

## Verification
Starvation detection can coincide with the sync-word or maintenance-slot decode. In those slots a low `dat_vld` must be ignored, while in any neighbouring data slot it must send a zero and set the flag. The bench holds `dat_vld` low across the maintenance symbol and the whole sync word with `dir_sel` = 1, then drops it once inside the data field. After every symbol the scoreboard checks the sent symbol, the `dat_take` strobe and the `underrun` level. This confirms that the flag stays clear through the framing slots and rises only at the starved data slot.

// File: rtl/tern_frame_mux.sv
module tern_frame_mux #(
  parameter int FRAME_LEN  = 120,
  parameter int SYNC_LEN   = 11,
  parameter int SYNC_POS_A = 0,
  parameter int SYNC_POS_B = 60,
  parameter logic [SYNC_LEN-1:0] BARKER = 11'b010_0100_0111
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sym_en,
  input  logic       dir_sel,
  input  logic       sync_inv,
  input  logic [1:0] dat_sym,
  input  logic       dat_vld,
  output logic       dat_take,
  input  logic [1:0] maint_sym,
  output logic [1:0] line_sym,
  output logic       line_vld,
  output logic       sof,
  output logic       underrun
);
  localparam int PW = $clog2(FRAME_LEN);
  localparam int SW = $clog2(SYNC_LEN);
  localparam logic [PW-1:0] BASE_A = PW'(SYNC_POS_A);
  localparam logic [PW-1:0] BASE_B = PW'(SYNC_POS_B);
  localparam logic [PW-1:0] M_A = (SYNC_POS_A == 0) ? PW'(FRAME_LEN-1) : PW'(SYNC_POS_A-1);
  localparam logic [PW-1:0] M_B = (SYNC_POS_B == 0) ? PW'(FRAME_LEN-1) : PW'(SYNC_POS_B-1);
  localparam logic [PW-1:0] LAST = PW'(FRAME_LEN-1);
  localparam logic [(2**SW)-1:0] BARKER_X = {{((2**SW)-SYNC_LEN){1'b0}}, BARKER};

  logic [PW-1:0] pos;
  logic [PW-1:0] base, mpos, off;
  logic          in_sync, in_m, in_data;
  logic [1:0]    sync_code, next_sym;

  function automatic logic [1:0] clean(input logic [1:0] s);
    return (s == 2'b10) ? 2'b00 : s;
  endfunction

  assign base    = dir_sel ? BASE_B : BASE_A;
  assign mpos    = dir_sel ? M_B : M_A;
  assign off     = pos - base;
  assign in_sync = ({1'b0, pos} >= {1'b0, base}) &&
                   ({1'b0, pos} < ({1'b0, base} + (PW+1)'(SYNC_LEN)));
  assign in_m    = (pos == mpos);
  assign in_data = !in_sync && !in_m;

  assign sync_code = (BARKER_X[off[SW-1:0]] ^ sync_inv) ? 2'b01 : 2'b11;
  assign next_sym  = in_sync ? sync_code :
                     in_m    ? clean(maint_sym) :
                     dat_vld ? clean(dat_sym) : 2'b00;
  assign dat_take  = sym_en && in_data && dat_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos      <= '0;
      line_sym <= 2'b00;
      line_vld <= 1'b0;
      sof      <= 1'b0;
      underrun <= 1'b0;
    end else begin
      line_vld <= sym_en;
      sof      <= sym_en && (pos == '0);
      if (sym_en) begin
        line_sym <= next_sym;
        pos      <= (pos == LAST) ? '0 : pos + 1'b1;
        if (in_data && !dat_vld) underrun <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tern_frame_mux_chk.sv
module tern_frame_mux_chk #(
  parameter int FRAME_LEN = 120
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sym_en,
  input logic       dat_vld,
  input logic       dat_take,
  input logic [1:0] line_sym,
  input logic       line_vld,
  input logic       sof,
  input logic       underrun
);
  int  cnt;
  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= 0;
      seen <= 1'b0;
    end else if (line_vld) begin
      cnt  <= sof ? 1 : cnt + 1;
      seen <= seen | sof;
    end
  end

  // R2
  out_follows_en_chk: assert property (@(posedge clk) disable iff (!rst_n) sym_en |=> line_vld);
  // R2
  no_idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n) !sym_en |=> !line_vld);
  // R3
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n) line_vld |-> line_sym != 2'b10);
  // R7
  take_qual_chk: assert property (@(posedge clk) disable iff (!rst_n) dat_take |-> (sym_en && dat_vld));
  // R8
  urun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) underrun |=> underrun);
  // R8
  urun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(underrun) |-> $past(sym_en && !dat_vld));
  // R9
  sof_vld_chk: assert property (@(posedge clk) disable iff (!rst_n) sof |-> line_vld);
  // R9
  sof_period_chk: assert property (@(posedge clk) disable iff (!rst_n) (sof && seen) |-> cnt == FRAME_LEN);
endmodule

bind tern_frame_mux tern_frame_mux_chk #(.FRAME_LEN(FRAME_LEN)) u_chk (.*);

// File: tb/test_tern_frame_mux.sv
`timescale 1ns/1ps
module test_tern_frame_mux;
  localparam int FL = 120;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sym_en = 1'b0, dir_sel = 1'b0, sync_inv = 1'b0, dat_vld = 1'b0;
  logic [1:0] dat_sym = 2'b00, maint_sym = 2'b00;
  logic dat_take, line_vld, sof, underrun;
  logic [1:0] line_sym;

  always #4 clk = ~clk;

  tern_frame_mux i_tern_frame_mux (
    .clk(clk), .rst_n(rst_n), .sym_en(sym_en), .dir_sel(dir_sel), .sync_inv(sync_inv),
    .dat_sym(dat_sym), .dat_vld(dat_vld), .dat_take(dat_take), .maint_sym(maint_sym),
    .line_sym(line_sym), .line_vld(line_vld), .sof(sof), .underrun(underrun));

  typedef struct { logic s; logic [1:0] sym; string tag; } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0;
  int pos = 0, dseq = 0;
  logic exp_urun = 1'b0;
  logic [1:0] msym = 2'b00;
  bit done = 0;
  localparam logic [10:0] BK = 11'b010_0100_0111;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (pos %0d)", req, act, exp, pos);
    end
  endtask

  function automatic logic [1:0] gen(input int n);
    case (n % 5)
      0: return 2'b01;
      1: return 2'b11;
      2: return 2'b00;
      3: return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

  function automatic logic [1:0] clean(input logic [1:0] s);
    return (s == 2'b10) ? 2'b00 : s;
  endfunction

  always @(negedge clk) begin
    if (rst_n && line_vld) begin
      exp_t e;
      if (q.size() == 0) chk(0, "R2", 1, 0);
      else begin
        e = q.pop_front();
        chk(line_sym === e.sym, e.tag, line_sym, e.sym);
        chk(sof === e.s, "R9", sof, e.s);
      end
    end
  end

  task automatic send(input logic vld);
    logic [1:0] d, e;
    string tag;
    bit take;
    int sbase, mp;
    @(negedge clk);
    chk(line_vld === 1'b0, "R2", line_vld, 0);
    d = gen(dseq);
    sym_en = 1'b1; dat_vld = vld; dat_sym = d; maint_sym = msym;
    sbase = dir_sel ? 60 : 0;
    mp = dir_sel ? 59 : 119;
    take = 0;
    if (pos >= sbase && pos < sbase + 11) begin
      e = (BK[pos - sbase] ^ sync_inv) ? 2'b01 : 2'b11;
      tag = sync_inv ? "R6" : (dir_sel ? "R5" : "R4");
    end else if (pos == mp) begin
      e = clean(msym);
      tag = "R10";
    end else begin
      take = vld;
      e = vld ? clean(d) : 2'b00;
      tag = vld ? ((d == 2'b10) ? "R3" : "R7") : "R8";
      if (!vld) exp_urun = 1'b1;
    end
    #1 chk(dat_take === take, "R7", dat_take, take);
    q.push_back('{pos == 0, e, tag});
    if (take) dseq++;
    pos = (pos + 1) % FL;
    @(negedge clk);
    sym_en = 1'b0; dat_vld = 1'b0;
    chk(underrun === exp_urun, "R8", underrun, exp_urun);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    pos = 0; exp_urun = 1'b0;
    q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk(line_vld === 1'b0, "R1", line_vld, 0);
    chk(sof === 1'b0, "R1", sof, 0);
    chk(underrun === 1'b0, "R1", underrun, 0);
    chk(line_sym === 2'b00, "R1", line_sym, 0);

    // R4 direction 0, normal polarity, two frames
    dir_sel = 1'b0; sync_inv = 1'b0;
    for (int f = 0; f < 2; f++) begin
      msym = (f == 0) ? 2'b11 : 2'b10;
      for (int p = 0; p < FL; p++) send(1'b1);
    end

    // R5 direction 1, inverted sync (R6)
    do_reset();
    dir_sel = 1'b1; sync_inv = 1'b1;
    msym = 2'b01;
    for (int p = 0; p < FL; p++) send(1'b1);

    // R10 starve through maintenance and sync slots, then R8 in data
    msym = 2'b11;
    for (int p = 0; p < FL; p++) send(!((p >= 59 && p <= 70) || p == 90));
    sync_inv = 1'b0;
    for (int p = 0; p < FL; p++) send(1'b1);

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R2", q.size(), 0);
    chk(underrun === 1'b1, "R8", underrun, 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule